// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block holds the eight 16-bit general registers of a small processor core. Each register is picked with a 3-bit index. Two read ports are combinational. One write port commits on the rising clock edge. The four lower-indexed registers hold data. Each can be used as one word or as two separate bytes, the low half and the high half. The four upper-indexed registers hold pointers and indexes, and they accept word access only.

Some instructions use registers without naming them, so the block drives a few side outputs straight from storage:

- the full counter register, used as the loop and string-operation count;
- the low byte of the counter register, used as the variable shift and rotate amount;
- the stack pointer.

A push input moves the stack pointer down by two and a pop input moves it up by two. These adjustments take effect in the same edge that would commit a write.

Register index encoding:

| Index | Register |
|-------|----------|
| 0 | accumulator |
| 1 | counter |
| 2 | data |
| 3 | base |
| 4 | stack pointer |
| 5 | frame pointer |
| 6 | source index |
| 7 | destination index |

Size code encoding, the same on every port:

| Code | Access |
|------|--------|
| 00 | word |
| 01 | low byte |
| 10 | high byte |
| 11 | reserved |

A byte write takes its value from `wr_data[7:0]`.

Top module: `gpr_bank`

## Requirements
- R1: While `rst_n` is low, all eight registers are cleared to zero and `size_err` is 0. On the first cycle after reset, every read and every side output returns 0.
- R2: A word write (size 00) to any index replaces the whole register at the clock edge. Either read port with size 00 then returns the new value.
- R3: A low-byte write (size 01) to index 0–3 replaces bits 7:0 with `wr_data[7:0]` and keeps bits 15:8.
- R4: A high-byte write (size 10) to index 0–3 replaces bits 15:8 with `wr_data[7:0]` and keeps bits 7:0.
- R5: A byte read of index 0–3 returns the selected half zero-extended: size 01 returns `{8'h00, reg[7:0]}` and size 10 returns `{8'h00, reg[15:8]}`.
- R6: A write request with size 01 or 10 to index 4–7, or with size 11 to any index, changes no register. `size_err` is 1 for exactly the cycle after that edge. In every other case `size_err` is 0.
- R7: A read with size 01 or 10 of index 4–7, or with size 11 of any index, returns 16'h0000.
- R8: `count_word` always equals register 1, and `shift_count` equals its bits 7:0.
- R9: `stack_ptr` always equals register 4.
- R10: With no word write to index 4, push alone lowers register 4 by 2 and pop alone raises it by 2, both modulo 2^16. Push and pop together leave it unchanged.
- R11: A word write to index 4 in the same cycle as push or pop stores `wr_data` and ignores the adjustment. A rejected byte write to index 4 lets the adjustment take effect.
- R12: Reads are not bypassed. In the cycle of a write, a read of the target returns the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_sel | input | 3 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 3 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write request |
| wr_sel | input | 3 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| push | input | 1 | Lower the stack pointer by 2 |
| pop | input | 1 | Raise the stack pointer by 2 |
| size_err | output | 1 | One-cycle flag for a rejected write |
| count_word | output | 16 | Counter register contents |
| shift_count | output | 8 | Low byte of the counter register |
| stack_ptr | output | 16 | Stack pointer contents |

## Verification
Writes to one accumulator alternate word, low-byte and high-byte sizes with distinct patterns. A wrong lane or a missing merge therefore shows up as a visible nibble mismatch.

Illegal requests are checked in several forms:

- byte writes and byte reads aimed at pointer registers;
- the reserved size code;

Each is followed by a word read of the target, to show that it left the stored value intact.

Stack traffic starts from zero so that the first push must wrap to 16'hFFFE. It is then combined with explicit word writes and rejected byte writes to the stack pointer, which tells the priority rule apart from the adjustment path.

A same-cycle write and read of one register separates a bypassed read from a true register read.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_LO   = 2'b01,
    SZ_HI   = 2'b10,
    SZ_RSV  = 2'b11
  } gpr_size_e;

endpackage

// File: rtl/gpr_access_check.sv
module gpr_access_check
  import gpr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       size,
  output logic             legal
);

  function automatic logic access_ok(input logic [SEL_W-1:0] s, input logic [1:0] z);
    logic is_byte;
    is_byte = (gpr_size_e'(z) == SZ_LO) || (gpr_size_e'(z) == SZ_HI);
    if (gpr_size_e'(z) == SZ_WORD) return 1'b1;
    return is_byte && (int'(s) < NUM_DATA);
  endfunction

  assign legal = access_ok(sel, size);

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int W        = 16,
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int SEL_W  = $clog2(NUM_REGS),
  localparam int HALF_W = W / 2
) (
  input  logic [NUM_REGS-1:0][W-1:0] regs,
  input  logic [SEL_W-1:0]           sel,
  input  logic [1:0]                 size,
  output logic [W-1:0]               data
);

  logic rd_legal;

  gpr_access_check #(
    .NUM_REGS(NUM_REGS),
    .NUM_DATA(NUM_DATA)
  ) u_acc (
    .sel  (sel),
    .size (size),
    .legal(rd_legal)
  );

  function automatic logic [W-1:0] extract(input logic [W-1:0] word, input logic [1:0] z);
    case (gpr_size_e'(z))
      SZ_LO:   return {{(W-HALF_W){1'b0}}, word[HALF_W-1:0]};
      SZ_HI:   return {{(W-HALF_W){1'b0}}, word[W-1:HALF_W]};
      default: return word;
    endcase
  endfunction

  assign data = rd_legal ? extract(regs[sel], size) : '0;

endmodule

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl #(
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [1:0]          wr_size,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic                wr_illegal,
  output logic                size_err
);

  logic wr_legal;

  gpr_access_check #(
    .NUM_REGS(NUM_REGS),
    .NUM_DATA(NUM_DATA)
  ) u_acc (
    .sel  (wr_sel),
    .size (wr_size),
    .legal(wr_legal)
  );

  assign wr_illegal = wr_en && !wr_legal;

  always_comb begin
    wr_hit = '0;
    if (wr_en && wr_legal) wr_hit[wr_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) size_err <= 1'b0;
    else        size_err <= wr_illegal;
  end

endmodule

// File: rtl/gpr_stack_adj.sv
module gpr_stack_adj #(
  parameter int W    = 16,
  parameter int STEP = 2
) (
  input  logic [W-1:0] cur,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] next,
  output logic         adj_active
);

  function automatic logic [W-1:0] stack_move(input logic [W-1:0] v, input logic dn, input logic up);
    if (dn && !up) return v - W'(STEP);
    if (up && !dn) return v + W'(STEP);
    return v;
  endfunction

  assign next       = stack_move(cur, push, pop);
  assign adj_active = push ^ pop;

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int W          = 16,
  parameter int NUM_REGS   = 8,
  parameter int NUM_DATA   = 4,
  parameter int CNT_IDX    = 1,
  parameter int SP_IDX     = 4,
  parameter int STACK_STEP = 2,
  localparam int SEL_W  = $clog2(NUM_REGS),
  localparam int HALF_W = W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_a_sel,
  input  logic [1:0]        rd_a_size,
  output logic [W-1:0]      rd_a_data,
  input  logic [SEL_W-1:0]  rd_b_sel,
  input  logic [1:0]        rd_b_size,
  output logic [W-1:0]      rd_b_data,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_size,
  input  logic [W-1:0]      wr_data,
  input  logic              push,
  input  logic              pop,
  output logic              size_err,
  output logic [W-1:0]      count_word,
  output logic [HALF_W-1:0] shift_count,
  output logic [W-1:0]      stack_ptr
);

  logic [NUM_REGS-1:0][W-1:0] regs_q;
  logic [NUM_REGS-1:0]        wr_hit;
  logic                       wr_illegal;
  logic [W-1:0]               sp_next;
  logic                       sp_adj;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] d,
                                         input logic [1:0] z);
    case (gpr_size_e'(z))
      SZ_LO:   return {old[W-1:HALF_W], d[HALF_W-1:0]};
      SZ_HI:   return {d[HALF_W-1:0], old[HALF_W-1:0]};
      default: return d;
    endcase
  endfunction

  gpr_write_ctrl #(
    .NUM_REGS(NUM_REGS),
    .NUM_DATA(NUM_DATA)
  ) u_wctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_size   (wr_size),
    .wr_hit    (wr_hit),
    .wr_illegal(wr_illegal),
    .size_err  (size_err)
  );

  gpr_stack_adj #(
    .W   (W),
    .STEP(STACK_STEP)
  ) u_stk (
    .cur       (regs_q[SP_IDX]),
    .push      (push),
    .pop       (pop),
    .next      (sp_next),
    .adj_active(sp_adj)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [W-1:0] q;
    if (i == SP_IDX) begin : g_sp
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (wr_hit[i]) q <= merge(q, wr_data, wr_size);
        else if (sp_adj)    q <= sp_next;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (wr_hit[i]) q <= merge(q, wr_data, wr_size);
      end
    end
    assign regs_q[i] = q;
  end

  localparam int NPORTS = 2;
  logic [NPORTS-1:0][SEL_W-1:0] rp_sel;
  logic [NPORTS-1:0][1:0]       rp_size;
  logic [NPORTS-1:0][W-1:0]     rp_data;

  assign rp_sel  = {rd_b_sel, rd_a_sel};
  assign rp_size = {rd_b_size, rd_a_size};

  for (genvar p = 0; p < NPORTS; p++) begin : g_rport
    gpr_read_port #(
      .W       (W),
      .NUM_REGS(NUM_REGS),
      .NUM_DATA(NUM_DATA)
    ) u_rp (
      .regs(regs_q),
      .sel (rp_sel[p]),
      .size(rp_size[p]),
      .data(rp_data[p])
    );
  end

  assign rd_a_data   = rp_data[0];
  assign rd_b_data   = rp_data[1];
  assign count_word  = regs_q[CNT_IDX];
  assign shift_count = regs_q[CNT_IDX][HALF_W-1:0];
  assign stack_ptr   = regs_q[SP_IDX];

endmodule

// File: rtl/gpr_bank_checker.sv
module gpr_bank_checker #(
  parameter int W          = 16,
  parameter int NUM_REGS   = 8,
  parameter int NUM_DATA   = 4,
  parameter int CNT_IDX    = 1,
  parameter int SP_IDX     = 4,
  parameter int STACK_STEP = 2,
  localparam int SEL_W  = $clog2(NUM_REGS),
  localparam int HALF_W = W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [1:0]        wr_size,
  input logic [W-1:0]      wr_data,
  input logic              push,
  input logic              pop,
  input logic              size_err,
  input logic [W-1:0]      count_word,
  input logic [HALF_W-1:0] shift_count,
  input logic [W-1:0]      stack_ptr
);

  logic bad_req, sp_word_wr, cnt_lo_wr, cnt_hi_wr;
  assign bad_req    = wr_en && ((wr_size == 2'b11) ||
                      (wr_size != 2'b00 && int'(wr_sel) >= NUM_DATA));
  assign sp_word_wr = wr_en && int'(wr_sel) == SP_IDX && wr_size == 2'b00;
  assign cnt_lo_wr  = wr_en && int'(wr_sel) == CNT_IDX && wr_size == 2'b01;
  assign cnt_hi_wr  = wr_en && int'(wr_sel) == CNT_IDX && wr_size == 2'b10;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stack_ptr == '0 && count_word == '0 && !size_err));

  assert_lo_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lo_wr |=> (count_word[W-1:HALF_W] == $past(count_word[W-1:HALF_W]) &&
                   count_word[HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

  assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hi_wr |=> (count_word[HALF_W-1:0] == $past(count_word[HALF_W-1:0]) &&
                   count_word[W-1:HALF_W] == $past(wr_data[HALF_W-1:0])));

  assert_err_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> size_err);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_req |=> !size_err);

  assert_shift_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_count == count_word[HALF_W-1:0]);

  assert_push_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !sp_word_wr) |=> stack_ptr == $past(stack_ptr) - W'(STACK_STEP));

  assert_pop_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !sp_word_wr) |=> stack_ptr == $past(stack_ptr) + W'(STACK_STEP));

  assert_push_pop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push && !sp_word_wr && !(wr_en && int'(wr_sel) == SP_IDX)) |=> $stable(stack_ptr));

  assert_sp_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp_word_wr |=> stack_ptr == $past(wr_data));

endmodule

bind gpr_bank gpr_bank_checker #(
  .W(W), .NUM_REGS(NUM_REGS), .NUM_DATA(NUM_DATA),
  .CNT_IDX(CNT_IDX), .SP_IDX(SP_IDX), .STACK_STEP(STACK_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
  .wr_data(wr_data), .push(push), .pop(pop), .size_err(size_err),
  .count_word(count_word), .shift_count(shift_count), .stack_ptr(stack_ptr)
);

// File: tb/gpr_bank_bench.sv
module gpr_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [1:0]  rd_a_size = '0, rd_b_size = '0, wr_size = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, push = 1'b0, pop = 1'b0;
  logic        size_err;
  logic [15:0] count_word, stack_ptr;
  logic [7:0]  shift_count;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpr_bank u_gpr_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
    .push(push), .pop(pop), .size_err(size_err),
    .count_word(count_word), .shift_count(shift_count), .stack_ptr(stack_ptr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at the falling edge, let the rising edge take it,
  // then clear the request 1 ns after the edge
  task automatic cycle(input logic we, input logic [2:0] s, input logic [1:0] z,
                       input logic [15:0] d, input logic pu, input logic po);
    @(negedge clk);
    wr_en = we; wr_sel = s; wr_size = z; wr_data = d; push = pu; pop = po;
    @(posedge clk);
    #1;
    wr_en = 1'b0; push = 1'b0; pop = 1'b0;
  endtask

  // {wr_en, wr_sel, wr_size, wr_data, rd_sel, rd_size, expected}
  localparam int NV = 14;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 3'd0, 2'd0, 16'h1234, 3'd0, 2'd0, 16'h1234},
    {1'b1, 3'd0, 2'd1, 16'h00AB, 3'd0, 2'd0, 16'h12AB},
    {1'b1, 3'd0, 2'd2, 16'h00CD, 3'd0, 2'd0, 16'hCDAB},
    {1'b0, 3'd0, 2'd0, 16'h0000, 3'd0, 2'd1, 16'h00AB},
    {1'b0, 3'd0, 2'd0, 16'h0000, 3'd0, 2'd2, 16'h00CD},
    {1'b1, 3'd1, 2'd0, 16'h0F0F, 3'd1, 2'd2, 16'h000F},
    {1'b1, 3'd1, 2'd2, 16'h00EE, 3'd1, 2'd0, 16'hEE0F},
    {1'b1, 3'd6, 2'd0, 16'hBEEF, 3'd6, 2'd0, 16'hBEEF},
    {1'b1, 3'd6, 2'd1, 16'h0011, 3'd6, 2'd0, 16'hBEEF},
    {1'b1, 3'd2, 2'd3, 16'h5555, 3'd2, 2'd0, 16'h0000},
    {1'b0, 3'd0, 2'd0, 16'h0000, 3'd6, 2'd1, 16'h0000},
    {1'b1, 3'd7, 2'd0, 16'h0102, 3'd7, 2'd0, 16'h0102},
    {1'b1, 3'd5, 2'd0, 16'hA5A5, 3'd5, 2'd0, 16'hA5A5},
    {1'b1, 3'd3, 2'd0, 16'h7777, 3'd3, 2'd0, 16'h7777}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 7, 11, 12, 13: return "R2 word write";
      1:                return "R3 low byte write";
      2, 6:             return "R4 high byte write";
      3, 4, 5:          return "R5 byte read zero-extended";
      8, 9:             return "R6 rejected write leaves register";
      default:          return "R7 illegal byte read";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: everything clear after reset
    for (int r = 0; r < 8; r++) begin
      rd_a_sel = 3'(r); rd_a_size = 2'd0;
      #1 check($sformatf("R1 reg %0d after reset", r), rd_a_data, 16'h0000);
    end
    check("R1 size_err after reset", {15'h0, size_err}, 16'h0000);
    check("R1 stack_ptr after reset", stack_ptr, 16'h0000);

    // main table
    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][42], VEC[i][41:39], VEC[i][38:37], VEC[i][36:21], 1'b0, 1'b0);
      rd_a_sel = VEC[i][20:18]; rd_a_size = VEC[i][17:16];
      #1 check($sformatf("%s vec %0d", vec_req(i), i), rd_a_data, VEC[i][15:0]);
    end

    // R8: implicit counter outputs
    check("R8 count_word", count_word, 16'hEE0F);
    check("R8 shift_count", {8'h00, shift_count}, 16'h000F);

    // R2 / R5 on port B
    rd_b_sel = 3'd6; rd_b_size = 2'd0;
    #1 check("R2 port B word read", rd_b_data, 16'hBEEF);
    rd_b_sel = 3'd0; rd_b_size = 2'd1;
    #1 check("R5 port B low byte read", rd_b_data, 16'h00AB);

    // R7: reserved size read on a data register
    rd_a_sel = 3'd0; rd_a_size = 2'd3;
    #1 check("R7 reserved size read", rd_a_data, 16'h0000);

    // R6: one-cycle error pulse, register untouched
    cycle(1'b1, 3'd5, 2'd2, 16'h00FF, 1'b0, 1'b0);
    rd_a_sel = 3'd5; rd_a_size = 2'd0;
    #1 check("R6 size_err raised", {15'h0, size_err}, 16'h0001);
    check("R6 frame pointer kept", rd_a_data, 16'hA5A5);
    cycle(1'b0, 3'd0, 2'd0, 16'h0000, 1'b0, 1'b0);
    check("R6 size_err one cycle only", {15'h0, size_err}, 16'h0000);

    // R9 / R10: stack adjust from zero
    rd_a_sel = 3'd4; rd_a_size = 2'd0;
    cycle(1'b0, 3'd0, 2'd0, 16'h0000, 1'b1, 1'b0);
    check("R10 push wraps", stack_ptr, 16'hFFFE);
    #1 check("R9 stack_ptr equals register 4", rd_a_data, stack_ptr);
    cycle(1'b0, 3'd0, 2'd0, 16'h0000, 1'b0, 1'b1);
    check("R10 pop back to zero", stack_ptr, 16'h0000);
    cycle(1'b0, 3'd0, 2'd0, 16'h0000, 1'b0, 1'b1);
    check("R10 pop raises by 2", stack_ptr, 16'h0002);
    cycle(1'b0, 3'd0, 2'd0, 16'h0000, 1'b1, 1'b1);
    check("R10 push and pop together hold", stack_ptr, 16'h0002);

    // R11: explicit write priority
    cycle(1'b1, 3'd4, 2'd0, 16'h1000, 1'b1, 1'b0);
    check("R11 write beats push", stack_ptr, 16'h1000);
    cycle(1'b1, 3'd4, 2'd0, 16'h2000, 1'b0, 1'b1);
    check("R11 write beats pop", stack_ptr, 16'h2000);
    cycle(1'b1, 3'd4, 2'd1, 16'h00FF, 1'b1, 1'b0);
    check("R11 rejected byte write lets push act", stack_ptr, 16'h1FFE);
    check("R11 rejected byte write flags error", {15'h0, size_err}, 16'h0001);

    // R12: no bypass of the write data
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_size = 2'd0; wr_data = 16'h4444;
    rd_a_sel = 3'd0; rd_a_size = 2'd0;
    #1 check("R12 old value before edge", rd_a_data, 16'hCDAB);
    @(posedge clk);
    #1 wr_en = 1'b0;
    check("R12 new value after edge", rd_a_data, 16'h4444);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule